// File: doc/BRIEF.md
# MII Receive Preamble Regenerator

This block sits on the receive side of a 4-bit MII data path. A PHY that is still locking its clock at the start of a frame can drop up to ten bits of the preamble, so what reaches the MAC side may begin with a short, ragged run of preamble nibbles. The regenerator scans the nibble stream for the start-of-frame delimiter. For every frame it replaces whatever preamble arrived with a fixed, full-length preamble and a delimiter, then forwards the frame body unchanged.

Each output frame is longer than its input frame. Body nibbles that arrive while the regenerated preamble is still being sent wait in an internal FIFO, and the FIFO drains during the inter-frame gap. Start and end markers travel through the same FIFO as the data, so the output sequencer learns frame boundaries in the same order as the nibbles themselves.

The input side has no ready, because a PHY cannot be stalled: a nibble is taken on every clock edge where `in_valid` is high. The output side is valid/ready. While `out_valid` is high and `out_ready` is low, the output holds its nibble and waits. Stalls add to the FIFO backlog, so the stall cycles allowed during a frame, plus the 18 entries of growth per frame, must fit within `FIFO_DEPTH`.

Top module: `mii_pre_regen`

## Requirements
- R1: After reset, `out_valid` is low until a frame with a valid delimiter has been received.
- R2: Every forwarded frame starts with exactly `PRE_LEN` (15) nibbles of value 0x5, followed by one nibble 0xD. This holds whatever number of 0x5 nibbles arrived, from 1 up to more than 15.
- R3: Every nibble received with `in_valid` high after the delimiter, up to the fall of `in_valid`, is forwarded once, in order and unchanged, straight after the regenerated delimiter. Body values 0x5 and 0xD are treated as ordinary data.
- R4: A delimiter counts only if it is a 0xD received with `in_valid` high directly after one or more 0x5 nibbles. A frame produces no output if it starts with 0xD, or if any value other than 0x5 appears before the delimiter. The rest of such a frame is ignored until `in_valid` falls.
- R5: If `in_valid` falls before a delimiter has been seen, the partial input is discarded and `out_valid` stays low.
- R6: After the last body nibble of a frame is accepted, `out_valid` is low in the next cycle. Consecutive output frames are therefore separated by at least one cycle with `out_valid` low, and `out_valid` does not drop inside a frame.
- R7: With `out_ready` high, `out_valid` is still low after the clock edge that samples the delimiter. After the following edge, `out_valid` is high and the first preamble nibble 0x5 is on `out_nibble`.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_nibble` keeps its value on the next cycle, and nothing is lost.
- R9: The FIFO never overflows or underflows when the gap between frames is at least 6 cycles and the total stall cycles stay within the backlog margin. Frames that arrive while earlier frames are still draining come out complete and in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock, one nibble per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Receive data valid from the PHY |
| in_nibble | input | 4 | Receive data nibble from the PHY |
| out_valid | output | 1 | Output nibble valid |
| out_ready | input | 1 | Downstream can accept a nibble this cycle |
| out_nibble | output | 4 | Output data nibble |

## Verification
The first regenerated nibble is due two rising edges after the delimiter is sampled. One edge latches the start marker into the FIFO; the second moves the sequencer into its preamble state. The directed latency check samples `out_valid` at the falling edge after each of those two edges. Body nibbles reach the output a variable number of cycles after they enter, depending on the backlog and on stalls, so the bench compares them by order against a queue built by its own functions. It does not assume a fixed delay. Frame length is checked at the first falling edge where `out_valid` is low after a run. Hold behaviour is checked one cycle after each stalled cycle.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  localparam int NIB_W = 4;

  typedef enum logic [1:0] {
    K_DATA = 2'd0,
    K_SOF  = 2'd1,
    K_EOF  = 2'd2
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [NIB_W-1:0]  nib;
  } entry_t;

  typedef enum logic [1:0] {
    D_IDLE = 2'd0,
    D_PRE  = 2'd1,
    D_BODY = 2'd2,
    D_DROP = 2'd3
  } det_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_PRE  = 2'd1,
    S_SFD  = 2'd2,
    S_BODY = 2'd3
  } seq_e;
endpackage

// File: rtl/mpr_sfd_detect.sv
module mpr_sfd_detect
  import mpr_pkg::*;
#(
  parameter logic [NIB_W-1:0] PRE_NIB = 4'h5,
  parameter logic [NIB_W-1:0] SFD_NIB = 4'hD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [NIB_W-1:0] in_nibble,
  output logic             push,
  output entry_t           push_entry
);
  det_e st, st_nxt;

  always_comb begin
    st_nxt     = st;
    push       = 1'b0;
    push_entry = '{kind: K_DATA, nib: in_nibble};
    case (st)
      D_IDLE: begin
        if (in_valid) st_nxt = (in_nibble == PRE_NIB) ? D_PRE : D_DROP;
      end
      D_PRE: begin
        if (!in_valid) begin
          st_nxt = D_IDLE;
        end else if (in_nibble == SFD_NIB) begin
          push       = 1'b1;
          push_entry = '{kind: K_SOF, nib: in_nibble};
          st_nxt     = D_BODY;
        end else if (in_nibble != PRE_NIB) begin
          st_nxt = D_DROP;
        end
      end
      D_BODY: begin
        push = 1'b1;
        if (!in_valid) begin
          push_entry = '{kind: K_EOF, nib: in_nibble};
          st_nxt     = D_IDLE;
        end
      end
      default: begin
        if (!in_valid) st_nxt = D_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= D_IDLE;
    else        st <= st_nxt;
  end

  // R4: a start marker is only written right after a preamble nibble was taken
  p_sof_after_pre_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && push_entry.kind == K_SOF) |-> ($past(in_valid) && $past(in_nibble) == PRE_NIB))
    else $error("p_sof_after_pre_r4");

endmodule

// File: rtl/mpr_nibble_fifo.sv
module mpr_nibble_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_ptr, rd_ptr;
  logic         full;

  assign empty   = (wr_ptr == rd_ptr);
  assign full    = (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]) && (wr_ptr[AW] != rd_ptr[AW]);
  assign rd_data = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  // R9: writes never land on a full buffer
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full)
    else $error("p_no_overflow_r9");

  // R9: reads never take from an empty buffer
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty)
    else $error("p_no_underflow_r9");

endmodule

// File: rtl/mpr_out_seq.sv
module mpr_out_seq
  import mpr_pkg::*;
#(
  parameter int               PRE_LEN = 15,
  parameter logic [NIB_W-1:0] PRE_NIB = 4'h5,
  parameter logic [NIB_W-1:0] SFD_NIB = 4'hD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  entry_t           head,
  input  logic             empty,
  output logic             pop,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [NIB_W-1:0] out_nibble
);
  localparam int CW = $clog2(PRE_LEN + 1);

  seq_e          st, st_nxt;
  logic [CW-1:0] cnt, cnt_nxt;

  always_comb begin
    st_nxt     = st;
    cnt_nxt    = cnt;
    pop        = 1'b0;
    out_valid  = 1'b0;
    out_nibble = PRE_NIB;
    case (st)
      S_IDLE: begin
        if (!empty) begin
          pop = 1'b1;
          if (head.kind == K_SOF) begin
            st_nxt  = S_PRE;
            cnt_nxt = '0;
          end
        end
      end
      S_PRE: begin
        out_valid = 1'b1;
        if (out_ready) begin
          if (cnt == CW'(PRE_LEN - 1)) st_nxt = S_SFD;
          else                         cnt_nxt = cnt + 1'b1;
        end
      end
      S_SFD: begin
        out_valid  = 1'b1;
        out_nibble = SFD_NIB;
        if (out_ready) st_nxt = S_BODY;
      end
      default: begin
        if (!empty) begin
          if (head.kind == K_DATA) begin
            out_valid  = 1'b1;
            out_nibble = head.nib;
            pop        = out_ready;
          end else begin
            pop    = 1'b1;
            st_nxt = S_IDLE;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_nxt;
      cnt <= cnt_nxt;
    end
  end

  // R8: a stalled output keeps its nibble
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_nibble)))
    else $error("p_hold_r8");

  // R2: every output frame opens with a preamble nibble
  p_frame_opens_pre_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_nibble == PRE_NIB))
    else $error("p_frame_opens_pre_r2");

  // R6: valid drops only in the cycle right after an end marker was seen
  p_valid_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(pop) && $past(out_ready))
    else $error("p_valid_drop_r6");

endmodule

// File: rtl/mii_pre_regen.sv
module mii_pre_regen
  import mpr_pkg::*;
#(
  parameter int               FIFO_DEPTH = 64,
  parameter int               PRE_LEN    = 15,
  parameter logic [NIB_W-1:0] PRE_NIB    = 4'h5,
  parameter logic [NIB_W-1:0] SFD_NIB    = 4'hD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [NIB_W-1:0] in_nibble,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [NIB_W-1:0] out_nibble
);
  localparam int ENT_W = $bits(entry_t);

  logic             push, pop, empty;
  entry_t           push_entry, head;
  logic [ENT_W-1:0] rd_vec;

  mpr_sfd_detect #(.PRE_NIB(PRE_NIB), .SFD_NIB(SFD_NIB)) u_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_nibble  (in_nibble),
    .push       (push),
    .push_entry (push_entry)
  );

  mpr_nibble_fifo #(.DEPTH(FIFO_DEPTH), .W(ENT_W)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (push),
    .wr_data (push_entry),
    .rd_en   (pop),
    .rd_data (rd_vec),
    .empty   (empty)
  );

  assign head = entry_t'(rd_vec);

  mpr_out_seq #(.PRE_LEN(PRE_LEN), .PRE_NIB(PRE_NIB), .SFD_NIB(SFD_NIB)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .head       (head),
    .empty      (empty),
    .pop        (pop),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_nibble (out_nibble)
  );

endmodule

// File: tb/mii_pre_regen_tb.sv
`timescale 1ns/1ps
module mii_pre_regen_tb;
  localparam int PRE_LEN = 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [3:0] in_nibble = 4'h0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [3:0] out_nibble;

  int checks = 0;
  int fails = 0;
  int stall_credit = 0;
  bit done = 1'b0;

  logic [3:0] exp_q[$];
  int         exp_len_q[$];

  always #2.5 clk = ~clk;

  mii_pre_regen u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_nibble(in_nibble),
    .out_valid(out_valid), .out_ready(out_ready), .out_nibble(out_nibble)
  );

  function automatic logic [3:0] exp_head_nib(int pos);
    return (pos < PRE_LEN) ? 4'h5 : 4'hD;
  endfunction

  function automatic logic [3:0] rand_nib();
    return 4'($urandom % 16);
  endfunction

  task automatic drive(bit v, logic [3:0] n);
    @(posedge clk); #1;
    in_valid = v;
    in_nibble = n;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(1'b0, rand_nib());
  endtask

  task automatic push_head();
    for (int i = 0; i <= PRE_LEN; i++) exp_q.push_back(exp_head_nib(i));
  endtask

  task automatic send_good(int npre, int nbody, int gap, int credit);
    stall_credit = credit;
    push_head();
    exp_len_q.push_back(PRE_LEN + 1 + nbody);
    for (int i = 0; i < npre; i++) drive(1'b1, 4'h5);
    drive(1'b1, 4'hD);
    for (int i = 0; i < nbody; i++) begin
      logic [3:0] b;
      b = rand_nib();
      exp_q.push_back(b);
      drive(1'b1, b);
    end
    idle(gap);
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0 || out_valid) @(negedge clk);
    @(negedge clk);
  endtask

  // kind 0: abort before delimiter (R5); 1: delimiter first (R4);
  // 2: foreign nibble leading (R4); 3: foreign nibble inside preamble (R4)
  task automatic send_bad(int kind);
    bit seen;
    wait_drain();
    stall_credit = 0;
    case (kind)
      0: for (int i = 0; i < 1 + $urandom % 14; i++) drive(1'b1, 4'h5);
      1: drive(1'b1, 4'hD);
      2: begin drive(1'b1, 4'h3); drive(1'b1, 4'h5); drive(1'b1, 4'hD); end
      default: begin
        drive(1'b1, 4'h5); drive(1'b1, 4'h7); drive(1'b1, 4'h5); drive(1'b1, 4'hD);
      end
    endcase
    if (kind != 0) for (int i = 0; i < 10; i++) drive(1'b1, rand_nib());
    drive(1'b0, 4'h0);
    seen = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (out_valid) seen = 1'b1;
    end
    checks++;
    if (seen) begin
      fails++;
      $display("FAIL %s: discarded frame kind %0d gave output, actual out_valid=1 expected 0",
               (kind == 0) ? "R5" : "R4", kind);
    end
  endtask

  // R7 directed latency check with ready held high
  task automatic latency_check();
    wait_drain();
    stall_credit = 0;
    push_head();
    exp_len_q.push_back(PRE_LEN + 1 + 4);
    drive(1'b1, 4'h5); drive(1'b1, 4'h5);
    drive(1'b1, 4'hD);
    for (int i = 0; i < 4; i++) begin
      logic [3:0] b;
      b = rand_nib();
      exp_q.push_back(b);
      drive(1'b1, b);
      if (i < 2) begin
        @(negedge clk);
        checks++;
        if (i == 0 && out_valid !== 1'b0) begin
          fails++;
          $display("FAIL R7: one edge after delimiter actual out_valid=%b expected 0", out_valid);
        end
        if (i == 1 && !(out_valid === 1'b1 && out_nibble === 4'h5)) begin
          fails++;
          $display("FAIL R7: two edges after delimiter actual valid=%b nib=%h expected 1/5",
                   out_valid, out_nibble);
        end
      end
    end
    idle(40);
  endtask

  // ready driver with bounded stalls per frame
  always @(posedge clk) begin
    #1;
    if (stall_credit > 0 && ($urandom % 10) == 0) begin
      out_ready = 1'b0;
      stall_credit = stall_credit - 1;
    end else begin
      out_ready = 1'b1;
    end
  end

  // output monitor: order-based scoreboard
  int         run_len = 0;
  logic       prev_stall = 1'b0;
  logic [3:0] prev_nib = 4'h0;
  always @(negedge clk) begin
    if (!rst_n) begin
      run_len = 0;
      prev_stall = 1'b0;
    end else begin
      if (prev_stall) begin
        checks++;
        if (!(out_valid === 1'b1 && out_nibble === prev_nib)) begin
          fails++;
          $display("FAIL R8: after stall actual valid=%b nib=%h expected 1/%h",
                   out_valid, out_nibble, prev_nib);
        end
      end
      if (out_valid && out_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R3: unexpected nibble actual %h expected none", out_nibble);
        end else begin
          logic [3:0] e;
          e = exp_q.pop_front();
          if (out_nibble !== e) begin
            fails++;
            $display("FAIL %s: position %0d actual %h expected %h",
                     (run_len <= PRE_LEN) ? "R2" : "R3", run_len, out_nibble, e);
          end
        end
        run_len++;
      end
      if (!out_valid && run_len > 0) begin
        checks++;
        if (exp_len_q.size() == 0) begin
          fails++;
          $display("FAIL R6: extra frame actual length %0d expected none", run_len);
        end else begin
          int el;
          el = exp_len_q.pop_front();
          if (run_len != el) begin
            fails++;
            $display("FAIL R6: frame length actual %0d expected %0d", run_len, el);
          end
        end
        run_len = 0;
      end
      prev_stall = out_valid && !out_ready;
      prev_nib = out_nibble;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: quiet after reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
        fails++;
        $display("FAIL R1: after reset actual out_valid=%b expected 0", out_valid);
      end
    end
    latency_check();
    // R2: short and over-long received preambles
    send_good(1, 8, 40, 0);
    send_good(20, 8, 40, 0);
    send_good(15, 1, 40, 0);
    // R4, R5 directed rejects
    for (int k = 0; k < 4; k++) send_bad(k);
    // R9: closely spaced frames stacking in the FIFO
    wait_drain();
    send_good(12, 20, 6, 0);
    send_good(13, 20, 6, 0);
    send_good(14, 20, 40, 0);
    // R8 and mixed random traffic
    for (int f = 0; f < 30; f++) begin
      int sel;
      sel = $urandom % 8;
      if (sel < 6) send_good(1 + $urandom % 15, 1 + $urandom % 60, 40 + $urandom % 8, 4);
      else send_bad($urandom % 4);
    end
    wait_drain();
    checks++;
    if (exp_q.size() != 0 || exp_len_q.size() != 0) begin
      fails++;
      $display("FAIL R3: leftover expected nibbles actual %0d expected 0", exp_q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule